// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block keeps the 64-bit product/remainder pair (HI and LO) of a 32-bit integer core and runs every instruction that touches it: signed and unsigned multiply, signed and unsigned divide, the four multiply-accumulate forms, the three-operand low-word multiply, and the four moves between general registers and HI/LO. The pipeline decodes the instruction into a 4-bit operation code, presents both source operands and pulses `start_i`. The block answers with a one-cycle `done_o`, and `result_o` carries the value a read operation produced.

Multiplies, accumulates and moves finish one clock after they are accepted. A divide runs a one-bit-per-clock restoring loop over the operand width. `busy_o` is high for the whole loop, and no request is taken while it is high. A requester that needs HI or LO holds `start_i` until `busy_o` drops, and that is the stall for a read that follows a divide.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset `busy_o`, `done_o` and `result_o` are 0, and HI and LO both read back as 0.
- R2: The operation codes are MULT=0x0, MULTU=0x1, DIV=0x2, DIVU=0x3, MFHI=0x4, MTHI=0x5, MFLO=0x6, MTLO=0x7, MADD=0x8, MADDU=0x9, MUL=0xA, MSUB=0xC and MSUBU=0xD. MULT (signed) and MULTU (unsigned) write bits 63:32 of the 64-bit product to HI and bits 31:0 to LO, and `done_o` pulses in the cycle after acceptance.
- R3: DIV and DIVU write the quotient to LO and the remainder to HI. `busy_o` is high for exactly 32 cycles after acceptance, and `done_o` pulses in the cycle after `busy_o` falls.
- R4: A signed divide truncates the quotient toward zero, and its remainder takes the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: Dividing by zero raises no fault. The quotient becomes 0xFFFFFFFF and the remainder equals the dividend, for both signed and unsigned divides.
- R6: MADD and MADDU add, and MSUB and MSUBU subtract, the signed or unsigned product to or from the 64-bit value {HI,LO}, and write the result back to HI and LO.
- R7: MUL returns the low 32 bits of the signed product on `result_o` with `done_o`, and leaves HI and LO unchanged.
- R8: MTHI and MTLO load `rs_i` into HI or LO in one cycle, and the next MFHI or MFLO returns the new value on `result_o` with its `done_o`.
- R9: A request presented while `busy_o` is high is not accepted: it produces no `done_o` and changes neither HI nor LO. When held, it is accepted on the first clock edge after `busy_o` falls.
- R10: `done_o` is never high while `busy_o` is high, and MFHI and MFLO return the HI or LO value as it stood at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when `busy_o` is low |
| op_i | input | 4 | Decoded operation code |
| rs_i | input | 32 | First source operand (dividend, multiplicand, move source) |
| rt_i | input | 32 | Second source operand (divisor, multiplier) |
| busy_o | output | 1 | Divide in progress; requests are not taken |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result of MFHI, MFLO or MUL, valid with `done_o` |

## Verification
Two events can fall in the same cycle: the divider's final write-back to HI/LO, and a move into LO that the requester keeps asserting through the whole divide. The bench starts a divide, switches the held request to MTLO at once, and keeps it asserted until `busy_o` drops. The scoreboard then expects exactly two completions, the divide's and the move's, in that order. A following MFLO must return the moved value and MFHI the remainder. If the move were taken too early, the quotient would overwrite it. If it were taken twice or dropped, the completion queue would not match.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [3:0] {
    OP_MULT  = 4'h0,
    OP_MULTU = 4'h1,
    OP_DIV   = 4'h2,
    OP_DIVU  = 4'h3,
    OP_MFHI  = 4'h4,
    OP_MTHI  = 4'h5,
    OP_MFLO  = 4'h6,
    OP_MTLO  = 4'h7,
    OP_MADD  = 4'h8,
    OP_MADDU = 4'h9,
    OP_MUL   = 4'hA,
    OP_MSUB  = 4'hC,
    OP_MSUBU = 4'hD
  } hilo_op_e;

  function automatic logic op_is_div(hilo_op_e op);
    return (op == OP_DIV) || (op == OP_DIVU);
  endfunction

  function automatic logic op_is_signed(hilo_op_e op);
    return (op == OP_MULT) || (op == OP_DIV) || (op == OP_MADD) ||
           (op == OP_MSUB) || (op == OP_MUL);
  endfunction
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int unsigned W = 32
) (
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W + 2;

  logic [W:0]           a_x, b_x;
  logic signed [PW-1:0] prod_full;

  // one extra bit makes one signed multiplier serve both interpretations
  assign a_x       = {signed_i & a_i[W-1], a_i};
  assign b_x       = {signed_i & b_i[W-1], b_i};
  assign prod_full = $signed(a_x) * $signed(b_x);
  assign prod_o    = prod_full[2*W-1:0];
endmodule

// File: rtl/hilo_acc.sv
module hilo_acc #(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [2*W-1:0] prod_i,
  input  logic           sub_i,
  output logic [2*W-1:0] sum_o
);
  always_comb begin
    if (sub_i) sum_o = acc_i - prod_i;
    else       sum_o = acc_i + prod_i;
  end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          negq_q, negr_q;

  logic [W-1:0]  dvd_mag, dvs_mag;
  logic [W:0]    trial, diff;
  logic          fits;
  logic [W-1:0]  rem_n, quo_n;

  assign dvd_mag = (signed_i && dvd_i[W-1]) ? (~dvd_i + 1'b1) : dvd_i;
  assign dvs_mag = (signed_i && dvs_i[W-1]) ? (~dvs_i + 1'b1) : dvs_i;

  // restoring step: shift next dividend bit in, subtract if it fits
  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = ~diff[W];
  assign rem_n = fits ? diff[W-1:0] : trial[W-1:0];
  assign quo_n = {quo_q[W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= dvd_mag;
      dvs_q  <= dvs_mag;
      // zero divisor keeps the all-ones magnitude quotient unsigned
      negq_q <= signed_i && (dvd_i[W-1] ^ dvs_i[W-1]) && (dvs_i != '0);
      negr_q <= signed_i && dvd_i[W-1];
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == LAST);
  assign quo_o  = negq_q ? (~quo_n + 1'b1) : quo_n;
  assign rem_o  = negr_q ? (~rem_n + 1'b1) : rem_n;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned DW = 2 * W;

  hilo_op_e     op;
  logic         accept;
  logic         div_busy, div_fin;
  logic [W-1:0] div_quo, div_rem;
  logic [DW-1:0] prod, acc_sum;
  logic [W-1:0] hi_q, lo_q, res_q;
  logic         done_q;

  assign op     = hilo_op_e'(op_i);
  assign accept = start_i && !div_busy;

  hilo_mul #(.W(W)) u_mul (
    .signed_i (op_is_signed(op)),
    .a_i      (rs_i),
    .b_i      (rt_i),
    .prod_o   (prod)
  );

  hilo_acc #(.W(W)) u_acc (
    .acc_i  ({hi_q, lo_q}),
    .prod_i (prod),
    .sub_i  ((op == OP_MSUB) || (op == OP_MSUBU)),
    .sum_o  (acc_sum)
  );

  hilo_div #(.W(W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept && op_is_div(op)),
    .signed_i (op == OP_DIV),
    .dvd_i    (rs_i),
    .dvs_i    (rt_i),
    .busy_o   (div_busy),
    .fin_o    (div_fin),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (div_fin) begin
        hi_q   <= div_rem;
        lo_q   <= div_quo;
        done_q <= 1'b1;
      end else if (accept && !op_is_div(op)) begin
        done_q <= 1'b1;
        unique case (op)
          OP_MULT, OP_MULTU: {hi_q, lo_q} <= prod;
          OP_MADD, OP_MADDU,
          OP_MSUB, OP_MSUBU: {hi_q, lo_q} <= acc_sum;
          OP_MUL:            res_q <= prod[W-1:0];
          OP_MFHI:           res_q <= hi_q;
          OP_MFLO:           res_q <= lo_q;
          OP_MTHI:           hi_q  <= rs_i;
          OP_MTLO:           lo_q  <= rs_i;
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = div_busy;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
  import hilo_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] rs_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int unsigned BW = $clog2(W + 1) + 1;

  logic [BW-1:0] bcnt;
  logic          take;

  assign take = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (bcnt == BW'(W)));

  p_div_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_div_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ((op_i == OP_DIV) || (op_i == OP_DIVU))) |=> busy_o);

  p_no_done_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  p_mul_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (op_i == OP_MUL)) |=> ($stable(hi_q) && $stable(lo_q)));

  p_mthi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (op_i == OP_MTHI)) |=> (hi_q == $past(rs_i)));

  p_mtlo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (op_i == OP_MTLO)) |=> (lo_q == $past(rs_i)));

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$fell(busy_o) && $past(busy_o) && !done_o && start_i) |=> (busy_o || done_o));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .rs_i    (rs_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_i = 4'h0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit          has_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_hi = '0, m_lo = '0;
  logic [31:0] seed = 32'h1357_9BDF;

  always #2 clk_i = ~clk_i;

  hilo_muldiv uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .rs_i(rs_i), .rt_i(rt_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [63:0] mdl_prod(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ax, bx;
    ax = sgn ? {{32{a[31]}}, a} : {32'b0, a};
    bx = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    return ax * bx;
  endfunction

  task automatic mdl_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] q, output logic [31:0] r);
    longint sa, sb;
    if (b == 0) begin
      q = '1; r = a;
    end else if (sgn) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      q = 32'(sa / sb); r = 32'(sa % sb);
    end else begin
      q = a / b; r = a % b;
    end
  endtask

  // expected state and result from the requirement, pushed at issue time
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output bit has, output logic [31:0] e);
    logic [63:0] p;
    logic [31:0] q, r;
    has = 0; e = '0;
    case (op)
      4'h0, 4'h1: begin p = mdl_prod(op == 4'h0, a, b); {m_hi, m_lo} = p; end
      4'h2, 4'h3: begin mdl_div(op == 4'h2, a, b, q, r); m_hi = r; m_lo = q; end
      4'h4: begin has = 1; e = m_hi; end
      4'h5: m_hi = a;
      4'h6: begin has = 1; e = m_lo; end
      4'h7: m_lo = a;
      4'h8, 4'h9: {m_hi, m_lo} = {m_hi, m_lo} + mdl_prod(op == 4'h8, a, b);
      4'hC, 4'hD: {m_hi, m_lo} = {m_hi, m_lo} - mdl_prod(op == 4'hC, a, b);
      4'hA: begin has = 1; p = mdl_prod(1, a, b); e = p[31:0]; end
      default: ;
    endcase
  endtask

  task automatic push(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
    bit h;
    logic [31:0] e;
    model(op, a, b, h, e);
    has_q.push_back(h); exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
    int n;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    start_i = 1; op_i = op; rs_i = a; rt_i = b;
    push(op, a, b, tag);
    @(negedge clk_i);
    start_i = 0;
    if (op == 4'h2 || op == 4'h3) begin
      n = 0;
      while (busy_o) begin n++; @(negedge clk_i); end
      check({"R3 busy length ", tag}, 32'(n), 32'd32);
    end
  endtask

  task automatic read_both(input string tag);
    issue(4'h4, '0, '0, {tag, " HI"});
    issue(4'h6, '0, '0, {tag, " LO"});
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (has_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        bit h;
        logic [31:0] e;
        string t;
        h = has_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        if (h) check(t, result_o, e);
      end
      if (busy_o) begin
        checks++; errors++;
        $display("FAIL R10 done while busy actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 busy at reset", 32'(busy_o), 0);
    check("R1 done at reset", 32'(done_o), 0);
    check("R1 result at reset", result_o, 0);
    rst_ni = 1;
    read_both("R1 reset");

    issue(4'h5, 32'h1234_5678, 0, "R8 mthi");
    issue(4'h4, 0, 0, "R8 mfhi after mthi");
    issue(4'h7, 32'hCAFE_F00D, 0, "R8 mtlo");
    issue(4'h6, 0, 0, "R8 mflo after mtlo");

    issue(4'h0, 32'hFFFF_FFFD, 32'd7, "R2 mult");
    read_both("R2 mult -3*7");
    issue(4'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 multu");
    read_both("R2 multu max");
    issue(4'h0, 32'h8000_0000, 32'h8000_0000, "R2 mult");
    read_both("R2 mult min*min");

    issue(4'h8, 32'hFFFF_FFFE, 32'd5, "R6 madd");
    read_both("R6 madd");
    issue(4'h9, 32'hF000_0000, 32'h10, "R6 maddu");
    read_both("R6 maddu");
    issue(4'hC, 32'd3, 32'hFFFF_FFFF, "R6 msub");
    read_both("R6 msub");
    issue(4'hD, 32'hFFFF_FFFF, 32'd2, "R6 msubu");
    read_both("R6 msubu");

    issue(4'hA, 32'hFFFF_FFF0, 32'd9, "R7 mul result");
    read_both("R7 hilo kept after mul");

    issue(4'h3, 32'd100, 32'd7, "R3 divu");
    read_both("R3 divu 100/7");
    issue(4'h2, 32'hFFFF_FFF9, 32'd2, "R4 div");
    read_both("R4 div -7/2");
    issue(4'h2, 32'd7, 32'hFFFF_FFFE, "R4 div");
    read_both("R4 div 7/-2");
    issue(4'h2, 32'h8000_0000, 32'hFFFF_FFFF, "R4 div");
    read_both("R4 div min/-1");
    issue(4'h3, 32'hDEAD_BEEF, 32'd0, "R5 divu");
    read_both("R5 divu by zero");
    issue(4'h2, 32'hF000_0001, 32'd0, "R5 div");
    read_both("R5 div neg by zero");

    // R9: request held through the divide, taken once after it
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    start_i = 1; op_i = 4'h3; rs_i = 32'd1000; rt_i = 32'd33;
    push(4'h3, 32'd1000, 32'd33, "R9 div under held request");
    @(negedge clk_i);
    op_i = 4'h7; rs_i = 32'hABCD_0123;
    push(4'h7, 32'hABCD_0123, 0, "R9 held mtlo");
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
    start_i = 0;
    read_both("R9 after held mtlo");

    for (int i = 0; i < 24; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      case (i % 8)
        0: op = 4'h0; 1: op = 4'h1; 2: op = 4'h2; 3: op = 4'h3;
        4: op = 4'h8; 5: op = 4'h9; 6: op = 4'hC; default: op = 4'hD;
      endcase
      a = nxt(); b = nxt();
      if (i % 5 == 4) b = b >> 20;
      issue(op, a, b, "R2 R3 R4 R6 mixed");
      read_both("R2 R3 R4 R6 mixed");
      issue(4'hA, a, b, "R7 mixed mul");
    end

    repeat (4) @(negedge clk_i);
    check("R10 scoreboard drained", 32'(has_q.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule